// File: doc/BRIEF.md
# DMA Channel Termination Tracker

This block follows one DMA channel from the moment a transfer is armed until it stops, and records why it stopped. When the channel is started it captures a block size and a transfer count. The product of the two is the number of unit transfers the channel must complete. A strobe from the transfer engine marks each completed unit. The tracker compares the running tally against the product and declares a normal end on the final unit.

While the channel is active, three abnormal causes can cut the transfer short: a stop request from an on-chip peripheral, a stop request from an external stop pin, and an address error. A separate channel reset input forces a reset termination. On every termination the block latches a 3-bit stop-source code. A normal end pulses the end interrupt. Any error pulses the error interrupt. A reset pulses neither.

The block has no data path. All of its pins are plain control and status levels or strobes, so it has no valid/ready handshake and no back-pressure.

Top module: `dma_end_tracker`

## Requirements
- R1: A `start` pulse while `busy` is low raises `busy` on the next cycle, clears `stop_src` to 000 and captures `blk_size` and `xfer_cnt`. A `start` while `busy` is high is ignored, and the transfer keeps the length captured at its own start.
- R2: The transfer length is the effective block size times the effective count. A zero field counts as 2^width: 16 for the 4-bit block size and 65536 for the 16-bit count.
- R3: After exactly that many `unit_done` strobes while busy, on the cycle after the last strobe: `busy` is low, `stop_src` is 001 and `end_irq` is high.
- R4: `periph_stop` while busy ends the transfer with code 010. `pin_stop` while busy ends it with code 011. Each raises `err_irq` on the next cycle.
- R5: `addr_err` while busy ends the transfer with code 100 and raises `err_irq` on the next cycle.
- R6: `chan_rst`, in any cycle and whether or not the channel is busy, clears `busy` and sets code 101 on the next cycle. It raises neither interrupt.
- R7: When causes coincide, the winner is chosen in this order: `chan_rst`, then `addr_err`, then `periph_stop`, then `pin_stop`, then the final unit strobe.
- R8: While `busy` is low, `unit_done`, `periph_stop`, `pin_stop` and `addr_err` have no effect on `busy`, `stop_src` or either interrupt.
- R9: Each interrupt is a single-cycle pulse, and the two interrupts are never high together. `stop_src` holds its value until the next accepted `start` or `chan_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset. Clears `busy`, the code and both interrupts |
| start | input | 1 | Arms the channel when it is idle |
| blk_size | input | BLK_W (4) | Block size, sampled at start. 0 means 2^BLK_W |
| xfer_cnt | input | CNT_W (16) | Transfer count, sampled at start. 0 means 2^CNT_W |
| unit_done | input | 1 | Strobe, one per completed unit transfer |
| periph_stop | input | 1 | Stop request from a peripheral |
| pin_stop | input | 1 | Stop request from the external stop pin |
| addr_err | input | 1 | Address error flag |
| chan_rst | input | 1 | Channel reset, classified as a reset termination |
| busy | output | 1 | Transfer in progress |
| stop_src | output | 3 | Latched termination cause: 000 none, 001 normal, 010 peripheral, 011 pin, 100 address, 101 reset |
| end_irq | output | 1 | One-cycle pulse on a normal end |
| err_irq | output | 1 | One-cycle pulse on an error termination |

## Verification
A unit tally or captured length that is off by even one unit shows at the ports on the very strobe concerned. The end interrupt and the fall of `busy` then arrive one strobe early or late, and the sweep of every block/count pair of a narrowed configuration catches that. A wrong priority or a misclassified cause shows as a wrong `stop_src` code or the wrong interrupt in the cycle right after the stimulus. A stuck-high pulse or a code that drifts while idle is seen within one cycle of the termination.

// File: rtl/dma_end_pkg.sv
package dma_end_pkg;
  typedef enum logic [2:0] {
    SRC_NONE   = 3'd0,
    SRC_NORMAL = 3'd1,
    SRC_PERIPH = 3'd2,
    SRC_PIN    = 3'd3,
    SRC_ADDR   = 3'd4,
    SRC_RESET  = 3'd5
  } stop_src_e;
endpackage

// File: rtl/dmaend_len_counter.sv
module dmaend_len_counter #(
  parameter int BLK_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BLK_W-1:0] cfg_blk,
  input  logic [CNT_W-1:0] cfg_cnt,
  input  logic             count_en,
  output logic             last_unit
);
  localparam int LEN_W = BLK_W + CNT_W + 1;

  logic [LEN_W-1:0] total_m1;
  logic [LEN_W-1:0] done_cnt;
  logic [LEN_W-1:0] eff_blk;
  logic [LEN_W-1:0] eff_cnt;
  logic [LEN_W-1:0] product;

  // a zero field stands for the full power-of-two range
  always_comb begin
    eff_blk = (cfg_blk == '0) ? (LEN_W'(1) << BLK_W) : LEN_W'(cfg_blk);
    eff_cnt = (cfg_cnt == '0) ? (LEN_W'(1) << CNT_W) : LEN_W'(cfg_cnt);
    product = eff_blk * eff_cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      total_m1 <= '0;
      done_cnt <= '0;
    end else if (load) begin
      total_m1 <= product - LEN_W'(1);
      done_cnt <= '0;
    end else if (count_en) begin
      done_cnt <= done_cnt + LEN_W'(1);
    end
  end

  assign last_unit = count_en && (done_cnt == total_m1);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count_en |-> (done_cnt <= total_m1)); // R3
endmodule

// File: rtl/dmaend_cause_arb.sv
module dmaend_cause_arb
  import dma_end_pkg::*;
(
  input  logic      busy,
  input  logic      chan_rst,
  input  logic      addr_err,
  input  logic      periph_stop,
  input  logic      pin_stop,
  input  logic      last_unit,
  output logic      fire,
  output logic      is_err,
  output logic      is_norm,
  output stop_src_e code
);
  always_comb begin
    fire    = 1'b1;
    is_err  = 1'b0;
    is_norm = 1'b0;
    code    = SRC_NONE;
    if (chan_rst) begin
      code = SRC_RESET;
    end else if (busy && addr_err) begin
      code   = SRC_ADDR;
      is_err = 1'b1;
    end else if (busy && periph_stop) begin
      code   = SRC_PERIPH;
      is_err = 1'b1;
    end else if (busy && pin_stop) begin
      code   = SRC_PIN;
      is_err = 1'b1;
    end else if (busy && last_unit) begin
      code    = SRC_NORMAL;
      is_norm = 1'b1;
    end else begin
      fire = 1'b0;
    end
  end
endmodule

// File: rtl/dma_end_tracker.sv
module dma_end_tracker
  import dma_end_pkg::*;
#(
  parameter int BLK_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BLK_W-1:0] blk_size,
  input  logic [CNT_W-1:0] xfer_cnt,
  input  logic             unit_done,
  input  logic             periph_stop,
  input  logic             pin_stop,
  input  logic             addr_err,
  input  logic             chan_rst,
  output logic             busy,
  output logic [2:0]       stop_src,
  output logic             end_irq,
  output logic             err_irq
);
  logic      load;
  logic      count_en;
  logic      last_unit;
  logic      fire;
  logic      is_err;
  logic      is_norm;
  stop_src_e arb_code;
  stop_src_e src_q;

  assign load     = start && !busy && !chan_rst;
  assign count_en = busy && unit_done;

  dmaend_len_counter #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_len (
    .clk(clk), .rst_n(rst_n), .load(load), .cfg_blk(blk_size),
    .cfg_cnt(xfer_cnt), .count_en(count_en), .last_unit(last_unit)
  );

  dmaend_cause_arb u_arb (
    .busy(busy), .chan_rst(chan_rst), .addr_err(addr_err),
    .periph_stop(periph_stop), .pin_stop(pin_stop), .last_unit(last_unit),
    .fire(fire), .is_err(is_err), .is_norm(is_norm), .code(arb_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      src_q   <= SRC_NONE;
      end_irq <= 1'b0;
      err_irq <= 1'b0;
    end else begin
      end_irq <= 1'b0;
      err_irq <= 1'b0;
      if (fire) begin
        busy    <= 1'b0;
        src_q   <= arb_code;
        end_irq <= is_norm;
        err_irq <= is_err;
      end else if (load) begin
        busy  <= 1'b1;
        src_q <= SRC_NONE;
      end
    end
  end

  assign stop_src = src_q;

  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(end_irq && err_irq)); // R9
  AST_END_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    end_irq |-> (stop_src == 3'd1 && !busy)); // R3
  AST_ERR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (stop_src == 3'd2 || stop_src == 3'd3 || stop_src == 3'd4)); // R4
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (end_irq || err_irq) |=> !(end_irq || err_irq)); // R9
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && !chan_rst) |=> $stable(stop_src)); // R9
  AST_RST_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> (stop_src == 3'd5 && !busy && !end_irq && !err_irq)); // R6
  AST_ADDR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && addr_err && !chan_rst) |=> (stop_src == 3'd4 && err_irq)); // R7
endmodule

// File: tb/dma_end_tracker_bench.sv
module dma_end_tracker_bench;
  localparam int CLK_P = 10;
  localparam int BW = 2;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [BW-1:0] blk_size = '0;
  logic [CW-1:0] xfer_cnt = '0;
  logic unit_done = 1'b0, periph_stop = 1'b0, pin_stop = 1'b0;
  logic addr_err = 1'b0, chan_rst = 1'b0;
  logic busy, end_irq, err_irq;
  logic [2:0] stop_src;
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dma_end_tracker #(.BLK_W(BW), .CNT_W(CW)) u_dma_end_tracker (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_size(blk_size),
    .xfer_cnt(xfer_cnt), .unit_done(unit_done), .periph_stop(periph_stop),
    .pin_stop(pin_stop), .addr_err(addr_err), .chan_rst(chan_rst),
    .busy(busy), .stop_src(stop_src), .end_irq(end_irq), .err_irq(err_irq)
  );

  task automatic chk(string rq, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // status vector: {busy,end_irq,err_irq,stop_src}
  function automatic int st();
    return {busy, end_irq, err_irq, stop_src};
  endfunction

  task automatic do_start(int b, int c);
    blk_size = BW'(b);
    xfer_cnt = CW'(c);
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic unit();
    unit_done = 1'b1;
    tick();
    unit_done = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R9 reset state", st(), 6'b000_000);

    // R2/R3: sweep every block/count pair of the narrowed configuration
    for (int b = 0; b < (1 << BW); b++) begin
      for (int c = 0; c < (1 << CW); c++) begin
        int tot;
        bit gap;
        tot = ((b == 0) ? (1 << BW) : b) * ((c == 0) ? (1 << CW) : c);
        gap = ((b + c) % 2) == 1;
        do_start(b, c);
        chk("R1 start arms", st(), 6'b100_000);
        for (int i = 0; i < tot; i++) begin
          if (gap) tick();
          unit();
          if (i < tot - 1) chk("R2 still busy before last unit", st(), 6'b100_000);
          else             chk("R3 normal end", st(), 6'b010_001);
        end
        tick();
        chk("R9 end pulse single and code held", st(), 6'b000_001);
      end
    end

    // R8: causes while idle are ignored
    unit_done = 1'b1; periph_stop = 1'b1; pin_stop = 1'b1; addr_err = 1'b1;
    tick();
    unit_done = 1'b0; periph_stop = 1'b0; pin_stop = 1'b0; addr_err = 1'b0;
    chk("R8 idle causes ignored", st(), 6'b000_001);
    tick(); tick();
    chk("R9 code holds while idle", st(), 6'b000_001);

    // R1: start while busy keeps the original length (1*2 = 2)
    do_start(1, 2);
    unit();
    do_start(3, 7);
    chk("R1 restart ignored", st(), 6'b100_000);
    unit();
    chk("R1 end at original length", st(), 6'b010_001);

    // R4/R5/R6: single causes midway through a 2*3 = 6 transfer
    do_start(2, 3); unit(); unit();
    periph_stop = 1'b1; tick(); periph_stop = 1'b0;
    chk("R4 peripheral stop", st(), 6'b001_010);
    tick();
    chk("R9 err pulse single", st(), 6'b000_010);

    do_start(2, 3); unit();
    pin_stop = 1'b1; tick(); pin_stop = 1'b0;
    chk("R4 pin stop", st(), 6'b001_011);

    do_start(2, 3); unit(); unit(); unit();
    addr_err = 1'b1; tick(); addr_err = 1'b0;
    chk("R5 address error", st(), 6'b001_100);

    do_start(2, 3); unit();
    chan_rst = 1'b1; tick(); chan_rst = 1'b0;
    chk("R6 reset while busy", st(), 6'b000_101);

    do_start(1, 1);
    chk("R1 start clears code", st(), 6'b100_000);
    unit();
    chk("R3 one-unit transfer", st(), 6'b010_001);
    chan_rst = 1'b1; tick(); chan_rst = 1'b0;
    chk("R6 reset while idle", st(), 6'b000_101);

    // R7: coincident causes on the final unit of a 1-unit transfer
    do_start(1, 1);
    unit_done = 1'b1; addr_err = 1'b1; periph_stop = 1'b1; pin_stop = 1'b1;
    tick();
    unit_done = 1'b0; addr_err = 1'b0; periph_stop = 1'b0; pin_stop = 1'b0;
    chk("R7 address error wins", st(), 6'b001_100);

    do_start(1, 1);
    unit_done = 1'b1; periph_stop = 1'b1; pin_stop = 1'b1;
    tick();
    unit_done = 1'b0; periph_stop = 1'b0; pin_stop = 1'b0;
    chk("R7 peripheral over pin", st(), 6'b001_010);

    do_start(1, 1);
    unit_done = 1'b1; pin_stop = 1'b1;
    tick();
    unit_done = 1'b0; pin_stop = 1'b0;
    chk("R7 pin over normal end", st(), 6'b001_011);

    do_start(1, 1);
    unit_done = 1'b1; addr_err = 1'b1; chan_rst = 1'b1;
    tick();
    unit_done = 1'b0; addr_err = 1'b0; chan_rst = 1'b0;
    chk("R7 reset over everything", st(), 6'b000_101);

    chan_rst = 1'b1; start = 1'b1; tick(); chan_rst = 1'b0; start = 1'b0;
    chk("R6 reset beats start", st(), 6'b000_101);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule